// File: doc/BRIEF.md
# Core Clock Divider Controller

This block produces the processor core's clock enable from a fast system clock. A single one-cycle enable pulse is issued every 2^N system clocks. N is a three-bit field in a byte-wide control register. The core logic advances only on cycles where the enable is high. A change of rate never cuts a core period short: a new ratio is loaded only when the period in progress ends.

A fast-interrupt option lets the core run at the full system rate while an interrupt is serviced. The interrupt logic holds a busy level high from entry to return. While that level and the option bit are both set, every period that starts is one system clock long. Once the level drops, the programmed ratio comes back at the next period boundary.

The same register also carries an oscillator power-down bit, which is driven to a dedicated output, and three bits that software cannot write. These are a lock flag from the frequency synthesizer, a reserved bit that always reads 0, and the level of an external strap pin captured during reset.

Top module: `coreclk_divider`

## Requirements
- R1: With divider field N (register bits 2:0) in force, `core_tick` is high for exactly one system clock in every 2^N system clocks, for every N from 0 to 7.
- R2: After reset, with `pll_locked` and `strap_pin` low, `reg_rdata` reads 0x03 and `osc_off` is low, so the core runs at one eighth of the system clock.
- R3: A new divider value written in the middle of a core period does not change that period. The period ends at the old length, and the periods after it use the new length.
- R4: While register bit 3 (fast-interrupt) and `irq_busy` are both high, every core period that starts is one system clock long, whatever the divider field holds.
- R5: When `irq_busy` falls, the core returns to periods of 2^N clocks, where N is the divider field. This starts from the first period that begins after the fall.
- R6: With bit 3 clear, `irq_busy` has no effect on the core period.
- R7: Bit 6 reads the `pll_locked` input after a two-flop synchronizer. Writes to bit 6 have no effect.
- R8: Bit 5 always reads 0, whatever was written to it.
- R9: Bit 4 returns the level of `strap_pin` sampled while reset is active. It holds that level after reset, whatever the pin does and whatever is written.
- R10: Bit 7 is written by software, and `osc_off` follows it from the cycle after the write.
- R11: On a cycle with `reg_we` high, bits 7, 3 and 2:0 take the values of `reg_wdata`, and `reg_rdata` shows them on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| strap_pin | input | 1 | External pin level, captured during reset |
| pll_locked | input | 1 | Lock indication from the frequency synthesizer (asynchronous) |
| irq_busy | input | 1 | High from interrupt entry until interrupt return |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| osc_off | output | 1 | Oscillator power-down control |
| core_tick | output | 1 | Core clock enable, one cycle wide |

## Verification
Two things can land on the same system clock: the end of a core period, where the next ratio is chosen, and a change in what that ratio should be. The change can come from a register write or from `irq_busy` rising or falling. The bench provokes this with a write 10 cycles into a 128-cycle period, and by toggling `irq_busy` while a period is in progress. It then measures the distance between `core_tick` pulses. The period in progress must keep its old length, and the next period must have the new length.

// File: rtl/coreclk_pkg.sv
package coreclk_pkg;

  // Divider field width; the counter and mask widths derive from it.
  localparam int DIV_W     = 3;
  localparam int CNT_W     = (1 << DIV_W) - 1;
  localparam int REG_W     = 8;

  // Bit positions read and written by software.
  localparam int POS_PD    = 7;
  localparam int POS_LOCK  = 6;
  localparam int POS_RSVD  = 5;
  localparam int POS_STRAP = 4;
  localparam int POS_FINT  = 3;

  localparam logic [DIV_W-1:0] DIV_RESET = 3'd3;

  typedef struct packed {
    logic             pd;
    logic             fint;
    logic [DIV_W-1:0] div;
  } ctrl_t;

endpackage

// File: rtl/coreclk_rst_sync.sv
module coreclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift a one in behind the asynchronous assertion.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = 1'b1;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/coreclk_ctrl_reg.sv
module coreclk_ctrl_reg
  import coreclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             pll_locked,
  input  logic             strap_pin,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] reg_rdata
);

  ctrl_t ctrl_q, ctrl_d;
  logic  lock_meta_q, lock_q;
  logic  strap_q;
  logic  strap_en;
  logic  unused_wdata_bits;

  // Only the writable fields are taken from the write data.
  assign unused_wdata_bits = ^reg_wdata[POS_LOCK:POS_STRAP];

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we) begin
      ctrl_d.pd   = reg_wdata[POS_PD];
      ctrl_d.fint = reg_wdata[POS_FINT];
      ctrl_d.div  = reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.pd   <= 1'b0;
      ctrl_q.fint <= 1'b0;
      ctrl_q.div  <= DIV_RESET;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // Two-flop synchronizer for the asynchronous lock flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_meta_q <= 1'b0;
      lock_q      <= 1'b0;
    end else begin
      lock_meta_q <= pll_locked;
      lock_q      <= lock_meta_q;
    end
  end

  // Strap capture: loaded only while reset is held, never reset itself.
  assign strap_en = ~rst_n;

  always_ff @(posedge clk) begin
    if (strap_en) strap_q <= strap_pin;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[POS_PD]      = ctrl_q.pd;
    reg_rdata[POS_LOCK]    = lock_q;
    reg_rdata[POS_RSVD]    = 1'b0;
    reg_rdata[POS_STRAP]   = strap_q;
    reg_rdata[POS_FINT]    = ctrl_q.fint;
    reg_rdata[DIV_W-1:0]   = ctrl_q.div;
  end

endmodule

// File: rtl/coreclk_rate_gen.sv
module coreclk_rate_gen
  import coreclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] target_div,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] term_mask;

  // Terminal count for ratio 2^act: the low act bits all ones.
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign term_mask[i] = (32'(act_q) > i);
    end
  endgenerate

  assign tick = (cnt_q == term_mask);

  // The ratio is reloaded only at the period boundary.
  always_comb begin
    if (tick) begin
      cnt_d = '0;
      act_d = target_div;
    end else begin
      cnt_d = cnt_q + 1'b1;
      act_d = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= DIV_RESET;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/coreclk_divider.sv
module coreclk_divider
  import coreclk_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_pin,
  input  logic             pll_locked,
  input  logic             irq_busy,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             osc_off,
  output logic             core_tick
);

  logic             rst_n_int;
  ctrl_t            ctrl;
  logic             fast_sel;
  logic [DIV_W-1:0] target_div;

  coreclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  coreclk_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .pll_locked (pll_locked),
    .strap_pin  (strap_pin),
    .ctrl       (ctrl),
    .reg_rdata  (reg_rdata)
  );

  // Interrupt override selects the undivided rate.
  assign fast_sel   = ctrl.fint & irq_busy;
  assign target_div = fast_sel ? '0 : ctrl.div;

  coreclk_rate_gen u_rate (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .target_div (target_div),
    .tick       (core_tick)
  );

  assign osc_off = ctrl.pd;

endmodule

// File: rtl/coreclk_divider_chk.sv
module coreclk_divider_chk
  import coreclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n_int,
  input logic             pll_locked,
  input logic             irq_busy,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             osc_off,
  input logic             core_tick
);

  // Cycles since the last core tick; sized to hold the longest period.
  logic [CNT_W:0] gap_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)     gap_q <= '0;
    else if (core_tick) gap_q <= '0;
    else                gap_q <= gap_q + 1'b1;
  end

  // R1: every period is a power of two no longer than 2^(2^DIV_W - 1).
  p_period_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    core_tick |-> ($countones(gap_q + 1'b1) == 1));

  // R4: a tick with the override active starts a one-cycle period.
  p_fast_irq_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(core_tick) && $past(irq_busy) && $past(reg_rdata[POS_FINT])) |-> core_tick);

  // R5: without the override a nonzero divider gives no back-to-back tick.
  p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(core_tick) && !$past(irq_busy) && ($past(reg_rdata[DIV_W-1:0]) != '0))
      |-> !core_tick);

  // R7: lock flag is the input two cycles back.
  p_lock_sync_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(rst_n_int) && $past(rst_n_int, 2)) |-> (reg_rdata[POS_LOCK] == $past(pll_locked, 2)));

  // R8: reserved bit is zero.
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_rdata[POS_RSVD] == 1'b0);

  // R9: strap bit stays put once out of reset.
  p_strap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    $past(rst_n_int) |-> $stable(reg_rdata[POS_STRAP]));

  // R10: power-down output follows the written bit.
  p_pd_write_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_we |=> (osc_off == $past(reg_wdata[POS_PD])));

  // R11: writable fields read back the written value.
  p_fields_write_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_we |=> (reg_rdata[POS_FINT:0] == $past(reg_wdata[POS_FINT:0])));

endmodule

bind coreclk_divider coreclk_divider_chk u_chk (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .pll_locked (pll_locked),
  .irq_busy   (irq_busy),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .osc_off    (osc_off),
  .core_tick  (core_tick)
);

// File: tb/coreclk_divider_bench.sv
`timescale 1ns/1ps
module coreclk_divider_bench;

  logic       clk;
  logic       rst_n;
  logic       strap_pin;
  logic       pll_locked;
  logic       irq_busy;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       osc_off;
  logic       core_tick;

  int checks;
  int errors;
  bit done;

  coreclk_divider u_coreclk_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_pin  (strap_pin),
    .pll_locked (pll_locked),
    .irq_busy   (irq_busy),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .osc_off    (osc_off),
    .core_tick  (core_tick)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    strap_pin = pin;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!core_tick) @(negedge clk);
  endtask

  task automatic measure_gap(output int gap);
    wait_tick();
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!core_tick);
  endtask

  task automatic t_reset();
    int g;
    do_reset(1'b0);
    check("R2 reset value", reg_rdata, 8'h03);
    check("R2 osc_off after reset", osc_off, 0);
    measure_gap(g);
    check("R2 default period", g, 8);
  endtask

  task automatic t_rates();
    int g;
    for (int n = 0; n < 8; n++) begin
      write_reg(8'(n));
      wait_tick();
      measure_gap(g);
      check($sformatf("R1 period for N=%0d", n), g, 1 << n);
    end
  endtask

  task automatic t_midperiod_change();
    int g;
    write_reg(8'h07);
    wait_tick();
    wait_tick();
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 10) begin
        reg_we = 1'b1;
        reg_wdata = 8'h01;
      end else begin
        reg_we = 1'b0;
      end
    end while (!core_tick);
    check("R3 current period keeps old length", g, 128);
    measure_gap(g);
    check("R3 next period uses new length", g, 2);
  endtask

  task automatic t_fast_irq();
    int g;
    write_reg(8'h0D);
    irq_busy = 1'b1;
    wait_tick();
    measure_gap(g);
    check("R4 override period", g, 1);
    measure_gap(g);
    check("R4 override stays", g, 1);
    @(negedge clk);
    irq_busy = 1'b0;
    measure_gap(g);
    check("R5 restored period", g, 32);
    measure_gap(g);
    check("R5 restored period again", g, 32);
  endtask

  task automatic t_fint_off();
    int g;
    write_reg(8'h02);
    irq_busy = 1'b1;
    wait_tick();
    measure_gap(g);
    check("R6 irq ignored with fint clear", g, 4);
    irq_busy = 1'b0;
  endtask

  task automatic t_lock();
    pll_locked = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 lock set", reg_rdata[6], 1);
    write_reg(8'h00);
    check("R7 write ignored (lock high)", reg_rdata[6], 1);
    pll_locked = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 lock clear", reg_rdata[6], 0);
    write_reg(8'h40);
    check("R7 write ignored (lock low)", reg_rdata[6], 0);
  endtask

  task automatic t_fields();
    write_reg(8'hFF);
    check("R8 reserved reads zero", reg_rdata[5], 0);
    check("R11 writable fields", {reg_rdata[7], reg_rdata[3:0]}, 5'h1F);
    check("R10 osc_off set", osc_off, 1);
    write_reg(8'h00);
    check("R10 osc_off clear", osc_off, 0);
    check("R11 cleared fields", {reg_rdata[7], reg_rdata[3:0]}, 5'h00);
  endtask

  task automatic t_strap();
    do_reset(1'b1);
    check("R9 strap captured high", reg_rdata[4], 1);
    strap_pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 strap held after pin change", reg_rdata[4], 1);
    write_reg(8'h00);
    check("R9 strap ignores write", reg_rdata[4], 1);
    do_reset(1'b0);
    check("R9 strap captured low", reg_rdata[4], 0);
    strap_pin = 1'b1;
    write_reg(8'h10);
    check("R9 strap low held", reg_rdata[4], 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    strap_pin = 1'b0;
    pll_locked = 1'b0;
    irq_busy = 1'b0;
    reg_we = 1'b0;
    reg_wdata = 8'h00;
    t_reset();
    t_rates();
    t_midperiod_change();
    t_fast_irq();
    t_fint_off();
    t_lock();
    t_fields();
    t_strap();
    finish_run();
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule